// File: doc/BRIEF.md
# Keyed GPIO Configuration Lock

This block is the register-bus slave that holds the pad configuration of one six-pin GPIO port. Software writes per-pin direction, input enable, pull-up, pull-down, open-drain and drive-strength bits, plus a 4-bit alternate-function selector per pin. The registers are driven straight out to the pad logic through the `cfg_*` outputs.

A lock register guards against stray writes. It accepts a write only when the upper half of the data carries the key value 0x5FA0. That one write seals the lock and records which pins are frozen. After that, configuration writes to those pins are dropped bit by bit or field by field, and pins that were not chosen stay writable. The seal cannot be changed, even by another keyed write. Only the active-low system reset or the synchronous port reset removes it.

The lock is a two-state machine. `ST_OPEN` is the state after any reset, and `ST_SEALED` is entered through the transition `ARM`, which is a lock-register write carrying the key. `ST_SEALED` has only a self-loop (`HOLD`), and its exit is the transition `CLEAR`, taken on either reset. `ST_OPEN` stays where it is (`IDLE`) on any other input.

Top module: `gcl_port_cfg`

## Requirements
- R1: After the system reset (`rst_n` low) every register reads 0x0000_0000 and all `cfg_*` outputs are zero.
- R2: While the port is open, a write with `wr_en` high stores data at the word address on the next clock edge. The word addresses are: 0 direction, 1 input enable, 2 pull-up, 3 pull-down, 4 open-drain, 5 drive strength, 6 alternate function, 7 lock. In registers 0 to 5, bit n belongs to pin n. In register 6, bits [4n+3:4n] belong to pin n. Reads are combinational from `addr` and are never blocked.
- R3: A write to address 7 whose bits [31:16] equal 0x5FA0 seals the port and latches bits [5:0] as the per-pin lock mask.
- R4: A write to address 7 with any other key value is discarded entirely. The status stays 0 and the mask stays 0.
- R5: Once the port is sealed, later writes to address 7 change nothing, even when they carry the key.
- R6: Reading address 7 returns the lock status in bit 16 (bits [31:17] are zero), the lock mask in bits [5:0], and zero in bits [15:6].
- R7: While the port is sealed with mask bit n set, writes leave pin n's bit unchanged in registers 0 to 5.
- R8: While the port is sealed with mask bit n set, writes leave pin n's 4-bit alternate-function field unchanged.
- R9: Pins whose mask bit is 0 stay writable in every configuration register after sealing, even within the same write that hits locked pins.
- R10: `port_rst` high at a clock edge clears the lock and all configuration registers at that edge.
- R11: In registers 0 to 5, bits [31:6] read as zero. In register 6, bits [31:24] read as zero. Writes to these bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| port_rst | input | 1 | Synchronous active-high port reset |
| addr | input | 3 | Word address of the register |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| cfg_dir | output | 6 | Per-pin direction |
| cfg_inen | output | 6 | Per-pin input enable |
| cfg_pu | output | 6 | Per-pin pull-up |
| cfg_pd | output | 6 | Per-pin pull-down |
| cfg_od | output | 6 | Per-pin open-drain |
| cfg_drv | output | 6 | Per-pin drive strength |
| cfg_af | output | 24 | 4-bit alternate-function select per pin |

## Verification
The properties assume that `wr_en`, `addr` and `wr_data` are settled at each rising edge, and that `port_rst` is sampled synchronously. For this reason, stability checks only apply to cycles in which `port_rst` is low. The bench changes every input on the falling edge, so inputs are stable at each rising edge. It asserts `port_rst` for exactly one full cycle. Random data is mixed with keyed lock writes, so the stimulus reaches both the sealed and the open paths, and occasional port resets return the lock to the open state.

// File: rtl/gcl_pkg.sv
package gcl_pkg;
    localparam int GCL_NPINS  = 6;
    localparam int GCL_AFW    = 4;
    localparam int GCL_DW     = 32;
    localparam int GCL_AW     = 3;
    localparam int GCL_NBITRG = 6;
    localparam logic [15:0] GCL_KEY = 16'h5FA0;

    typedef enum logic [2:0] {
        REG_DIR  = 3'd0,
        REG_INEN = 3'd1,
        REG_PU   = 3'd2,
        REG_PD   = 3'd3,
        REG_OD   = 3'd4,
        REG_DRV  = 3'd5,
        REG_AF   = 3'd6,
        REG_LOCK = 3'd7
    } reg_idx_e;

    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_SEALED = 1'b1
    } lock_state_e;
endpackage

// File: rtl/gcl_lock_ctrl.sv
module gcl_lock_ctrl
    import gcl_pkg::*;
#(
    parameter int NPINS = GCL_NPINS,
    parameter int DW    = GCL_DW,
    parameter logic [15:0] KEY = GCL_KEY
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_rst,
    input  logic             lock_wr,
    input  logic [DW-1:0]    wr_data,
    output logic             sealed,
    output logic [NPINS-1:0] lock_bits
);
    lock_state_e      state_q, state_d;
    logic [NPINS-1:0] mask_q;
    logic             arm;

    // next state
    always_comb begin
        state_d = state_q;
        arm     = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                if (lock_wr && (wr_data[DW-1 -: 16] == KEY)) begin
                    state_d = ST_SEALED;   // ARM
                    arm     = 1'b1;
                end
            end
            ST_SEALED: state_d = ST_SEALED; // HOLD
            default:   state_d = ST_OPEN;
        endcase
    end

    // state register (CLEAR on either reset)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
            mask_q  <= '0;
        end else if (port_rst) begin
            state_q <= ST_OPEN;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            if (arm) mask_q <= wr_data[NPINS-1:0];
        end
    end

    // outputs
    always_comb begin
        sealed    = (state_q == ST_SEALED);
        lock_bits = sealed ? mask_q : '0;
    end

    a_r5_seal_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sealed && !port_rst) |=> (sealed && $stable(lock_bits)));
    a_r4_bad_key_open: assert property (@(posedge clk) disable iff (!rst_n)
        (!sealed && lock_wr && wr_data[DW-1 -: 16] != KEY && !port_rst) |=> (!sealed && lock_bits == '0));
    a_r3_key_seals: assert property (@(posedge clk) disable iff (!rst_n)
        (!sealed && lock_wr && wr_data[DW-1 -: 16] == KEY && !port_rst) |=> (sealed && lock_bits == $past(wr_data[NPINS-1:0])));
    a_r10_port_clear: assert property (@(posedge clk) disable iff (!rst_n)
        port_rst |=> (!sealed && lock_bits == '0));
endmodule

// File: rtl/gcl_cfg_bank.sv
module gcl_cfg_bank
    import gcl_pkg::*;
#(
    parameter int NPINS = GCL_NPINS,
    parameter int AFW   = GCL_AFW,
    parameter int NBIT  = GCL_NBITRG,
    parameter int DW    = GCL_DW,
    parameter int AW    = GCL_AW
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       port_rst,
    input  logic                       wr_en,
    input  logic [AW-1:0]              sel,
    input  logic [DW-1:0]              wr_data,
    input  logic [NPINS-1:0]           lock_bits,
    output logic [NBIT-1:0][NPINS-1:0] bits_q,
    output logic [NPINS*AFW-1:0]       af_q
);
    localparam int AFTOT = NPINS * AFW;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
            af_q   <= '0;
        end else if (port_rst) begin
            bits_q <= '0;
            af_q   <= '0;
        end else if (wr_en) begin
            for (int r = 0; r < NBIT; r++) begin
                for (int p = 0; p < NPINS; p++) begin
                    if (sel == AW'(r) && !lock_bits[p]) bits_q[r][p] <= wr_data[p];
                end
            end
            for (int p = 0; p < NPINS; p++) begin
                if (sel == AW'(REG_AF) && !lock_bits[p]) af_q[p*AFW +: AFW] <= wr_data[p*AFW +: AFW];
            end
        end
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin_chk
        for (genvar r = 0; r < NBIT; r++) begin : g_reg_chk
            a_r7_locked_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (lock_bits[p] && !port_rst) |=> $stable(bits_q[r][p]));
        end
        a_r8_locked_af_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_bits[p] && !port_rst) |=> $stable(af_q[p*AFW +: AFW]));
        a_r9_free_pin_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (!lock_bits[p] && wr_en && sel == AW'(REG_AF) && !port_rst)
                |=> af_q[p*AFW +: AFW] == $past(wr_data[p*AFW +: AFW]));
    end

    if (AFTOT > DW) begin : g_bad_cfg
        initial $error("alternate-function fields exceed data width");
    end
endmodule

// File: rtl/gcl_port_cfg.sv
module gcl_port_cfg
    import gcl_pkg::*;
#(
    parameter int NPINS = GCL_NPINS,
    parameter int AFW   = GCL_AFW,
    parameter int DW    = GCL_DW,
    parameter int AW    = GCL_AW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 port_rst,
    input  logic [AW-1:0]        addr,
    input  logic                 wr_en,
    input  logic [DW-1:0]        wr_data,
    output logic [DW-1:0]        rd_data,
    output logic [NPINS-1:0]     cfg_dir,
    output logic [NPINS-1:0]     cfg_inen,
    output logic [NPINS-1:0]     cfg_pu,
    output logic [NPINS-1:0]     cfg_pd,
    output logic [NPINS-1:0]     cfg_od,
    output logic [NPINS-1:0]     cfg_drv,
    output logic [NPINS*AFW-1:0] cfg_af
);
    localparam int NBIT  = GCL_NBITRG;
    localparam int AFTOT = NPINS * AFW;

    logic                       sealed;
    logic [NPINS-1:0]           lock_bits;
    logic [NBIT-1:0][NPINS-1:0] bits_q;
    logic [AFTOT-1:0]           af_q;
    logic                       lock_wr;

    assign lock_wr = wr_en && (addr == AW'(REG_LOCK));

    gcl_lock_ctrl #(.NPINS(NPINS), .DW(DW)) u_lock (
        .clk(clk), .rst_n(rst_n), .port_rst(port_rst), .lock_wr(lock_wr),
        .wr_data(wr_data), .sealed(sealed), .lock_bits(lock_bits)
    );

    gcl_cfg_bank #(.NPINS(NPINS), .AFW(AFW), .NBIT(NBIT), .DW(DW), .AW(AW)) u_bank (
        .clk(clk), .rst_n(rst_n), .port_rst(port_rst), .wr_en(wr_en), .sel(addr),
        .wr_data(wr_data), .lock_bits(lock_bits), .bits_q(bits_q), .af_q(af_q)
    );

    always_comb begin
        rd_data = '0;
        if (addr == AW'(REG_LOCK)) begin
            rd_data[16]         = sealed;
            rd_data[NPINS-1:0]  = lock_bits;
        end else if (addr == AW'(REG_AF)) begin
            rd_data[AFTOT-1:0]  = af_q;
        end else begin
            rd_data[NPINS-1:0]  = bits_q[addr];
        end
    end

    assign cfg_dir  = bits_q[REG_DIR];
    assign cfg_inen = bits_q[REG_INEN];
    assign cfg_pu   = bits_q[REG_PU];
    assign cfg_pd   = bits_q[REG_PD];
    assign cfg_od   = bits_q[REG_OD];
    assign cfg_drv  = bits_q[REG_DRV];
    assign cfg_af   = af_q;

    a_r1_reset_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_dir == '0 && cfg_af == '0 && !sealed));
    a_r6_status_matches_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == AW'(REG_LOCK)) |-> (rd_data[16] == (lock_bits != '0 || sealed) || !sealed));
    a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != AW'(REG_LOCK) && addr != AW'(REG_AF)) |-> rd_data[DW-1:NPINS] == '0);
endmodule

// File: tb/gcl_port_cfg_tb.sv
module gcl_port_cfg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_rst = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [5:0]  cfg_dir, cfg_inen, cfg_pu, cfg_pd, cfg_od, cfg_drv;
    logic [23:0] cfg_af;

    int errors = 0;
    int checks = 0;

    logic [31:0] m_reg [7];
    logic        m_sealed;
    logic [5:0]  m_mask;

    always #2 clk = ~clk;

    gcl_port_cfg dut_i (
        .clk(clk), .rst_n(rst_n), .port_rst(port_rst), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .cfg_dir(cfg_dir), .cfg_inen(cfg_inen),
        .cfg_pu(cfg_pu), .cfg_pd(cfg_pd), .cfg_od(cfg_od), .cfg_drv(cfg_drv), .cfg_af(cfg_af)
    );

    function automatic void model_clear();
        for (int i = 0; i < 7; i++) m_reg[i] = '0;
        m_sealed = 1'b0;
        m_mask   = '0;
    endfunction

    function automatic void model_write(input logic [2:0] a, input logic [31:0] d);
        logic [5:0] open_pins;
        open_pins = m_sealed ? ~m_mask : 6'h3F;
        if (a == 3'd7) begin
            if (!m_sealed && d[31:16] == 16'h5FA0) begin
                m_sealed = 1'b1;
                m_mask   = d[5:0];
            end
        end else if (a == 3'd6) begin
            for (int p = 0; p < 6; p++)
                if (open_pins[p]) m_reg[6][p*4 +: 4] = d[p*4 +: 4];
        end else begin
            for (int p = 0; p < 6; p++)
                if (open_pins[p]) m_reg[a][p] = d[p];
        end
    endfunction

    function automatic logic [31:0] model_read(input logic [2:0] a);
        if (a == 3'd7) return {15'd0, m_sealed, 10'd0, m_mask};
        return m_reg[a];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_chk(input logic [2:0] a, input string req);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, rd_data, model_read(a));
    endtask

    task automatic outs_chk(input string req);
        #1;
        chk(req, {26'd0, cfg_dir},  m_reg[0]);
        chk(req, {26'd0, cfg_inen}, m_reg[1]);
        chk(req, {26'd0, cfg_pu},   m_reg[2]);
        chk(req, {26'd0, cfg_pd},   m_reg[3]);
        chk(req, {26'd0, cfg_od},   m_reg[4]);
        chk(req, {26'd0, cfg_drv},  m_reg[5]);
        chk(req, {8'd0, cfg_af},    m_reg[6]);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic do_port_rst();
        @(negedge clk);
        port_rst = 1'b1;
        @(negedge clk);
        port_rst = 1'b0;
        model_clear();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int unused;
        logic [2:0]  a;
        logic [31:0] d;
        unused = $urandom(32'h00C0_FFEE);
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 8; i++) read_chk(3'(i), "R1 reset value");
        outs_chk("R1 reset outputs");

        // R2 / R11 open writes with reserved bits set
        for (int i = 0; i < 7; i++) wr(3'(i), 32'hFFFF_FFC0 | 32'(i * 13 + 5));
        wr(3'd6, 32'hABCD_1234);
        for (int i = 0; i < 7; i++) read_chk(3'(i), "R2 R11 open write");
        outs_chk("R2 outputs follow");

        // R4 bad key discarded
        wr(3'd7, 32'h5FA1_003F);
        read_chk(3'd7, "R4 bad key");
        wr(3'd7, 32'h0000_003F);
        read_chk(3'd7, "R4 no key");

        // R3 keyed seal with mask 010110
        wr(3'd7, 32'h5FA0_FFD6);
        read_chk(3'd7, "R3 R6 seal and status");

        // R5 write once
        wr(3'd7, 32'h5FA0_0029);
        read_chk(3'd7, "R5 second keyed write");

        // R7 / R9 bit registers, R8 / R9 alternate function
        for (int i = 0; i < 6; i++) begin
            wr(3'(i), 32'h0000_0000);
            read_chk(3'(i), "R7 R9 clear attempt");
            wr(3'(i), 32'hFFFF_FFFF);
            read_chk(3'(i), "R7 R9 set attempt");
        end
        wr(3'd6, 32'h0000_0000);
        read_chk(3'd6, "R8 R9 af clear");
        wr(3'd6, 32'h5A5A_5A5A);
        read_chk(3'd6, "R8 R9 af write");
        outs_chk("R7 R8 outputs under lock");

        // R10 port reset clears seal and registers
        do_port_rst();
        for (int i = 0; i < 8; i++) read_chk(3'(i), "R10 port reset");
        outs_chk("R10 outputs");
        wr(3'd7, 32'h5FA0_0001);
        read_chk(3'd7, "R10 R3 reseal after port reset");

        // R1 system reset in the middle
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        read_chk(3'd7, "R1 system reset clears seal");

        // random phase
        for (int n = 0; n < 600; n++) begin
            a = 3'($urandom % 8);
            d = $urandom;
            if (a == 3'd7 && ($urandom % 3) == 0) d[31:16] = 16'h5FA0;
            if (($urandom % 60) == 0) do_port_rst();
            wr(a, d);
            read_chk(a, "R2 R5 R7 R8 R9 random");
            read_chk(3'd7, "R6 random status");
        end
        outs_chk("R2 random outputs");

        finish_run();
    end
endmodule